// File: doc/BRIEF.md
# Event Timer with Comparator Channels

The block is a memory-mapped event timer. A 64-bit main counter advances by one on every clock while a global run bit is set. Software can stop the counter, load either 32-bit half, and start it again. Up to four comparator channels watch the counter. A channel that matches latches a status bit, and that bit drives an interrupt line chosen by the channel's routing field. Read-only words report the block's capabilities and its tick length in femtoseconds.

Each channel runs in one of two modes. In one-shot mode it fires once, when the count equals its comparator. In periodic mode every match adds a stored 32-bit increment to the comparator. A set-value sequence lets software load the first match value and then the increment through the same comparator word. A 32-bit option limits the compare to the low half of the counter. A global legacy-routing bit takes channels 0 and 1 off the routed lines and drives them onto two dedicated outputs, a system tick line and a real-time-clock line.

Software accesses the block through a single-cycle 32-bit write port. Reads are combinational on the address.

Top module: `evtimer`

## Requirements
- R1: The global config word at 0x010 holds the run bit at bit 0. While run is 1 the counter rises by exactly one per clock, and while it is 0 the counter holds. Its low and high halves are read and written at 0x0F0 and 0x0F4, and a carry out of the low half reaches the high half.
- R2: The capability word at 0x000 reads revision 0x01 in bits [7:0], channel count minus one in bits [11:8] and legacy-routing support in bit 15. The word at 0x004 reads the fixed tick length in femtoseconds.
- R3: Channel i is mapped at 0x100 + 0x20*i. Its config word is at +0x00, with enable at bit 0, periodic at bit 1, set-value at bit 2, 32-bit compare at bit 3 and route at bits [7:4]. The comparator low half is at +0x08, the high half at +0x0C, and the read-only increment at +0x10. Unimplemented channels read zero.
- R4: An enabled channel with the counter running raises its status one clock after the count equals its comparator. In one-shot mode the comparator is left unchanged, so the channel does not fire again as the count moves on.
- R5: In periodic mode each match adds the 32-bit increment to the comparator, which is visible one clock later.
- R6: Writing the config word with both set-value and periodic at 1 arms a sequence. The next comparator-low write loads the comparator, and the one after it loads the increment and clears the set-value bit. Set-value written with periodic at 0 is ignored: it reads back 0, and a comparator-low write loads the comparator.
- R7: With the 32-bit bit set, a match needs only the low 32 bits of counter and comparator to agree. With it clear, all 64 bits must agree.
- R8: The status word at 0x020 has one bit per channel (bit i for channel i) and each bit stays set until cleared. Writing 1 to a bit clears it and writing 0 leaves it. A match in the same clock as the clear keeps the bit set.
- R9: Output irq_lines[r] is the OR of the status bits of every channel whose route field equals r.
- R10: When global config bit 1 (legacy) is set, channel 0 status drives tick_irq and channel 1 status drives rtc_irq, and neither channel reaches irq_lines. When the bit is clear, both dedicated outputs stay low.
- R11: After reset the counter, all config words, comparators, increments, status bits and interrupt outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one clock per write |
| addr | input | 12 | Byte address of the accessed word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for addr (combinational) |
| irq_lines | output | 16 | Routed interrupt levels |
| tick_irq | output | 1 | Legacy system tick interrupt |
| rtc_irq | output | 1 | Legacy real-time-clock interrupt |

## Verification
Assertions check on every clock that the counter rises by exactly one or holds according to the run bit. They also check that a periodic match advances the comparator by the increment and that a one-shot match leaves it unchanged. For the status bits, they check that a match latches the bit and that a clear without a match drops it. Only the bench scenarios can show the behaviour that depends on software sequences: the set-value write ordering, the exact cycle at which a programmed match first appears, 32-bit against 64-bit comparison across a nonzero high half, and the hand-over of channels 0 and 1 between routed and legacy outputs.

// File: rtl/evtimer_pkg.sv
package evtimer_pkg;

    localparam int CNT_W     = 64;
    localparam int REG_W     = 32;
    localparam int ROUTE_W   = 4;
    localparam int NUM_LINES = 1 << ROUTE_W;
    localparam int ADDR_W    = 12;

    localparam logic [ADDR_W-1:0] A_CAP    = 12'h000;
    localparam logic [ADDR_W-1:0] A_PERIOD = 12'h004;
    localparam logic [ADDR_W-1:0] A_GCFG   = 12'h010;
    localparam logic [ADDR_W-1:0] A_STATUS = 12'h020;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 12'h0F0;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 12'h0F4;

    localparam logic [3:0] CH_PAGE   = 4'h1;
    localparam logic [4:0] CH_CFG    = 5'h00;
    localparam logic [4:0] CH_CMP_LO = 5'h08;
    localparam logic [4:0] CH_CMP_HI = 5'h0C;
    localparam logic [4:0] CH_INCR   = 5'h10;

    typedef struct packed {
        logic [ROUTE_W-1:0] route;
        logic               narrow;
        logic               setval;
        logic               periodic;
        logic               enable;
    } chan_cfg_t;

    typedef struct packed {
        logic legacy;
        logic run;
    } gcfg_t;

    function automatic logic [REG_W-1:0] cap_word(int nch, bit legacy_ok, logic [7:0] rev);
        logic [REG_W-1:0] w;
        w        = '0;
        w[7:0]   = rev;
        w[11:8]  = 4'(nch - 1);
        w[15]    = legacy_ok;
        return w;
    endfunction

endpackage

// File: rtl/evtimer_counter.sv
module evtimer_counter
    import evtimer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [REG_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            if (run)
                cnt <= cnt + 1'b1;
            if (wr_lo)
                cnt[REG_W-1:0] <= wdata;
            if (wr_hi)
                cnt[CNT_W-1:REG_W] <= wdata;
        end
    end

    assert_count_step_R1: assert property (@(posedge clk) disable iff (rst)
        (run && !wr_lo && !wr_hi) |=> (cnt == $past(cnt) + 1'b1));

    assert_count_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_lo && !wr_hi) |=> $stable(cnt));

endmodule

// File: rtl/evtimer_channel.sv
module evtimer_channel
    import evtimer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt,
    input  logic             run,
    input  logic             wr_cfg,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic             clr,
    input  logic [REG_W-1:0] wdata,
    output chan_cfg_t        cfg_rd,
    output logic [CNT_W-1:0] cmp,
    output logic [REG_W-1:0] incr,
    output logic             sts
);

    chan_cfg_t cfg_q;
    chan_cfg_t cfg_new;
    logic      armed;
    logic      stage;
    logic      eq;
    logic      hit;

    assign cfg_new = chan_cfg_t'(wdata[7:0]);
    assign eq      = cfg_q.narrow ? (cnt[REG_W-1:0] == cmp[REG_W-1:0]) : (cnt == cmp);
    assign hit     = cfg_q.enable && run && eq;

    always_comb begin
        cfg_rd        = cfg_q;
        cfg_rd.setval = armed;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            armed <= 1'b0;
            stage <= 1'b0;
            cmp   <= '0;
            incr  <= '0;
            sts   <= 1'b0;
        end else begin
            if (hit && cfg_q.periodic)
                cmp <= cmp + CNT_W'(incr);
            if (wr_cfg) begin
                cfg_q        <= cfg_new;
                cfg_q.setval <= 1'b0;
                armed        <= cfg_new.setval && cfg_new.periodic;
                stage        <= 1'b0;
            end
            if (wr_lo) begin
                if (armed && stage) begin
                    incr  <= wdata;
                    armed <= 1'b0;
                    stage <= 1'b0;
                end else begin
                    cmp[REG_W-1:0] <= wdata;
                    if (armed)
                        stage <= 1'b1;
                end
            end
            if (wr_hi)
                cmp[CNT_W-1:REG_W] <= wdata;
            if (hit)
                sts <= 1'b1;
            else if (clr)
                sts <= 1'b0;
        end
    end

    assert_periodic_advance_R5: assert property (@(posedge clk) disable iff (rst)
        (hit && cfg_q.periodic && !wr_lo && !wr_hi && !wr_cfg)
        |=> (cmp == $past(cmp) + CNT_W'($past(incr))));

    assert_oneshot_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (hit && !cfg_q.periodic && !wr_lo && !wr_hi) |=> $stable(cmp));

    assert_match_latches_R8: assert property (@(posedge clk) disable iff (rst)
        hit |=> sts);

    assert_clear_drops_R8: assert property (@(posedge clk) disable iff (rst)
        (clr && !hit) |=> !sts);

endmodule

// File: rtl/evtimer_route.sv
module evtimer_route
    import evtimer_pkg::*;
#(
    parameter int NUM_CH = 3
)(
    input  logic [NUM_CH-1:0]              sts,
    input  logic [NUM_CH-1:0][ROUTE_W-1:0] routes,
    input  logic                           legacy,
    output logic [NUM_LINES-1:0]           lines,
    output logic                           tick,
    output logic                           rtc
);

    always_comb begin
        lines = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (!(legacy && c < 2))
                lines[routes[c]] = lines[routes[c]] | sts[c];
        end
    end

    assign tick = legacy && sts[0];

    generate
        if (NUM_CH > 1) begin : g_rtc
            assign rtc = legacy && sts[1];
        end else begin : g_no_rtc
            assign rtc = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/evtimer.sv
module evtimer
    import evtimer_pkg::*;
#(
    parameter int              NUM_CH    = 3,
    parameter logic [31:0]     PERIOD_FS = 32'd10000000,
    parameter bit              LEGACY_OK = 1'b1,
    parameter logic [7:0]      REV       = 8'h01
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [REG_W-1:0]     wr_data,
    output logic [REG_W-1:0]     rd_data,
    output logic [NUM_LINES-1:0] irq_lines,
    output logic                 tick_irq,
    output logic                 rtc_irq
);

    localparam logic [REG_W-1:0] CAP = cap_word(NUM_CH, LEGACY_OK, REV);

    gcfg_t            gcfg;
    logic [CNT_W-1:0] cnt;
    logic [1:0]       chsel;
    logic [4:0]       choff;
    logic             in_page;

    chan_cfg_t                    cfg_a  [NUM_CH];
    logic [CNT_W-1:0]             cmp_a  [NUM_CH];
    logic [REG_W-1:0]             incr_a [NUM_CH];
    logic [NUM_CH-1:0]            sts;
    logic [NUM_CH-1:0][ROUTE_W-1:0] routes;

    assign chsel   = addr[6:5];
    assign choff   = addr[4:0];
    assign in_page = (addr[11:8] == CH_PAGE) && !addr[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            gcfg <= '0;
        end else if (wr_en && addr == A_GCFG) begin
            gcfg.run    <= wr_data[0];
            gcfg.legacy <= wr_data[1] && LEGACY_OK;
        end
    end

    evtimer_counter u_counter (
        .clk   (clk),
        .rst   (rst),
        .run   (gcfg.run),
        .wr_lo (wr_en && addr == A_CNT_LO),
        .wr_hi (wr_en && addr == A_CNT_HI),
        .wdata (wr_data),
        .cnt   (cnt)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            logic sel;
            assign sel = wr_en && in_page && (int'(chsel) == c);
            evtimer_channel u_ch (
                .clk    (clk),
                .rst    (rst),
                .cnt    (cnt),
                .run    (gcfg.run),
                .wr_cfg (sel && choff == CH_CFG),
                .wr_lo  (sel && choff == CH_CMP_LO),
                .wr_hi  (sel && choff == CH_CMP_HI),
                .clr    (wr_en && addr == A_STATUS && wr_data[c]),
                .wdata  (wr_data),
                .cfg_rd (cfg_a[c]),
                .cmp    (cmp_a[c]),
                .incr   (incr_a[c]),
                .sts    (sts[c])
            );
            assign routes[c] = cfg_a[c].route;
        end
    endgenerate

    evtimer_route #(.NUM_CH(NUM_CH)) u_route (
        .sts    (sts),
        .routes (routes),
        .legacy (gcfg.legacy),
        .lines  (irq_lines),
        .tick   (tick_irq),
        .rtc    (rtc_irq)
    );

    always_comb begin
        rd_data = '0;
        if (in_page) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (int'(chsel) == c) begin
                    case (choff)
                        CH_CFG:    rd_data = REG_W'(cfg_a[c]);
                        CH_CMP_LO: rd_data = cmp_a[c][REG_W-1:0];
                        CH_CMP_HI: rd_data = cmp_a[c][CNT_W-1:REG_W];
                        CH_INCR:   rd_data = incr_a[c];
                        default:   rd_data = '0;
                    endcase
                end
            end
        end else begin
            case (addr)
                A_CAP:    rd_data = CAP;
                A_PERIOD: rd_data = PERIOD_FS;
                A_GCFG:   rd_data = REG_W'(gcfg);
                A_STATUS: rd_data = REG_W'(sts);
                A_CNT_LO: rd_data = cnt[REG_W-1:0];
                A_CNT_HI: rd_data = cnt[CNT_W-1:REG_W];
                default:  rd_data = '0;
            endcase
        end
    end

    assert_legacy_off_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (!gcfg.legacy) |-> (!tick_irq && !rtc_irq));

endmodule

// File: tb/evtimer_bench.sv
module evtimer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 9;

    localparam logic [11:0] VADDR [0:NV-1] = '{
        12'h000, 12'h004, 12'h010, 12'h020, 12'h0F0,
        12'h0F4, 12'h100, 12'h148, 12'h160
    };
    localparam logic [31:0] VEXP [0:NV-1] = '{
        32'h0000_8201, 32'd10000000, 32'h0, 32'h0, 32'h0,
        32'h0, 32'h0, 32'h0, 32'h0
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [15:0] irq_lines;
    logic        tick_irq;
    logic        rtc_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evtimer u_evtimer (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .irq_lines (irq_lines),
        .tick_irq  (tick_irq),
        .rtc_irq   (rtc_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic rdchk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11 and R2, R3: reset state table
        for (int i = 0; i < NV; i++)
            rdchk("R11/R2/R3 reset register", VADDR[i], VEXP[i]);
        chk("R11 irq outputs", {14'b0, tick_irq, rtc_irq, irq_lines}, 32'h0);

        // R1: carry from low half and hold
        wr(12'h0F0, 32'hFFFF_FFFE);
        wr(12'h010, 32'h1);
        repeat (3) @(negedge clk);
        rdchk("R1 count low after carry", 12'h0F0, 32'h1);
        rdchk("R1 count high after carry", 12'h0F4, 32'h1);
        wr(12'h010, 32'h0);
        begin
            logic [31:0] a, b;
            rd(12'h0F0, a);
            repeat (5) @(negedge clk);
            rd(12'h0F0, b);
            chk("R1 counter holds when stopped", b, a);
        end
        wr(12'h0F0, 32'h0);
        wr(12'h0F4, 32'h0);

        // R4, R8, R9: one-shot on channel 0, route 3
        wr(12'h100, 32'h31);
        wr(12'h108, 32'd20);
        wr(12'h010, 32'h1);
        repeat (20) @(negedge clk);
        chk("R4 no fire before match", 32'(irq_lines[3]), 32'h0);
        @(negedge clk);
        chk("R4/R9 fire on routed line", 32'(irq_lines[3]), 32'h1);
        rdchk("R8 status bit 0", 12'h020, 32'h1);
        rdchk("R4 one-shot comparator unchanged", 12'h108, 32'd20);
        wr(12'h020, 32'h0);
        chk("R8 write 0 keeps status", 32'(irq_lines[3]), 32'h1);
        wr(12'h020, 32'h1);
        chk("R8 write 1 clears status", 32'(irq_lines[3]), 32'h0);
        repeat (40) @(negedge clk);
        chk("R4 no refire after pass", 32'(irq_lines[3]), 32'h0);
        wr(12'h100, 32'h0);

        // R6, R5: periodic channel 1 with set-value, route 5
        wr(12'h010, 32'h0);
        wr(12'h0F0, 32'h0);
        wr(12'h120, 32'h57);
        rdchk("R6 set-value armed", 12'h120, 32'h57);
        wr(12'h128, 32'd10);
        rdchk("R6 still armed after first write", 12'h120, 32'h57);
        wr(12'h128, 32'd7);
        rdchk("R6 set-value cleared", 12'h120, 32'h53);
        rdchk("R6 comparator from first write", 12'h128, 32'd10);
        rdchk("R6 increment from second write", 12'h130, 32'd7);
        wr(12'h010, 32'h1);
        repeat (10) @(negedge clk);
        rdchk("R5 comparator before match", 12'h128, 32'd10);
        @(negedge clk);
        rdchk("R5 comparator after first match", 12'h128, 32'd17);
        chk("R9 periodic channel on line 5", 32'(irq_lines[5]), 32'h1);
        repeat (7) @(negedge clk);
        rdchk("R5 comparator after second match", 12'h128, 32'd24);

        // R10: legacy hand-over
        wr(12'h010, 32'h3);
        chk("R10 rtc line driven", 32'(rtc_irq), 32'h1);
        chk("R10 channel 1 off routed line", 32'(irq_lines[5]), 32'h0);
        chk("R10 tick idle", 32'(tick_irq), 32'h0);
        wr(12'h010, 32'h1);
        chk("R10 rtc low when legacy clear", 32'(rtc_irq), 32'h0);
        chk("R10 channel 1 back on line 5", 32'(irq_lines[5]), 32'h1);
        wr(12'h120, 32'h0);
        wr(12'h020, 32'h2);

        // R7: 64-bit vs 32-bit compare on channel 2, route 6
        wr(12'h010, 32'h0);
        wr(12'h0F0, 32'd5);
        wr(12'h0F4, 32'h1);
        wr(12'h140, 32'h61);
        wr(12'h148, 32'd8);
        wr(12'h010, 32'h1);
        repeat (6) @(negedge clk);
        chk("R7 64-bit compare misses", 32'(irq_lines[6]), 32'h0);
        wr(12'h010, 32'h0);
        wr(12'h0F0, 32'd5);
        wr(12'h140, 32'h69);
        wr(12'h010, 32'h1);
        repeat (3) @(negedge clk);
        chk("R7 no fire before low match", 32'(irq_lines[6]), 32'h0);
        @(negedge clk);
        chk("R7 32-bit compare fires", 32'(irq_lines[6]), 32'h1);
        rdchk("R1 high half kept", 12'h0F4, 32'h1);

        // R6: set-value without periodic is ignored
        wr(12'h010, 32'h0);
        wr(12'h140, 32'h65);
        rdchk("R6 set-value ignored without periodic", 12'h140, 32'h61);
        wr(12'h148, 32'h33);
        rdchk("R6 write loads comparator", 12'h148, 32'h33);
        rdchk("R6 increment untouched", 12'h150, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule